// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns one 32-bit fixed-length instruction word into the full set of control strobes that a single-cycle processor datapath needs in the same cycle. It covers register-format, immediate-format and jump-format instructions. It also takes a branch-condition flag that the datapath ALU produces, and uses it to steer the next-PC selection. All paths are combinational, so every output follows the instruction and the PC+4 value with no register in between.

The block has two outputs besides the control strobes. The first is the absolute jump target, built from the upper PC+4 bits and the word-aligned 26-bit jump field. The second is the word-aligned, sign-extended branch displacement, which the datapath adds to PC+4. Register-indirect jumps are reported through a single flag. They take no extra next-PC mux option. Instructions the block does not recognise raise a flag, and all of their side-effect enables stay low.

Top module: `ctrl_decoder`

Bit fields of the instruction are: op = [31:26], rs = [25:21], rt = [20:16], rd = [15:11], shamt = [10:6], fn = [5:0], imm16 = [15:0], imm26 = [25:0].

## Requirements
- R1: `regDstRd` is 1 exactly when op equals 0, and 0 for every other op value, whether that op is legal or not.
- R2: `aluSrcImm` is 1 exactly when op is nonzero and is neither 4 (branch-equal) nor 5 (branch-not-equal).
- R3: `memRead` and `memToReg` are 1 only for op 35 (load word). `memWrite` is 1 only for op 43 (store word).
- R4: `regWrite` is 1 for these cases: op 0 with fn in {0,2,32,34,36,37,38,39,42}, op 0 with fn 9, op 3, the immediate ops {8,10,12,13,14}, and op 35. It is 0 for op 43, ops 4 to 7, op 2, op 0 with fn 8, and every illegal word.
- R5: `pcSelJump` is 1 exactly when op is 2 or 3.
- R6: `pcSelBranch` is 1 exactly when op is in 4..7 and `brCond` is 1. A set `brCond` has no effect on any other op.
- R7: For op 0, `aluOp` is taken from fn. The mapping is fn 32 to ADD (0), 34 to SUB (1), 36 to AND (2), 37 to OR (3), 38 to XOR (4), 39 to NOR (5), 0 to SLL (6), 2 to SRL (7) and 42 to SLT (8). Any other fn gives ADD.
- R8: The immediate ops map as 8 to ADD, 10 to SLT, 12 to AND, 13 to OR and 14 to XOR. Ops 35 and 43 select ADD. Ops 2 and 3, and illegal ops, give ADD.
- R9: The branch ops select a condition code: op 4 gives EQ (9), 5 gives NE (10), 6 gives LEZ (11) and 7 gives GTZ (12).
- R10: `jumpTarget` equals {pcPlus4[31:28], instr[25:0], 2'b00}.
- R11: `branchOffset` equals instr[15:0] sign-extended to 32 bits and shifted left by 2, so pcPlus4 + `branchOffset` is the branch target.
- R12: `regJump` is 1 exactly for op 0 with fn 8 or fn 9. Of these two, only fn 9 sets `regWrite`.
- R13: `illegalInstr` is 1 for any op outside {0,2,3,4,5,6,7,8,10,12,13,14,35,43}, and for op 0 with fn outside {0,2,8,9,32,34,36,37,38,39,42}. While it is 1, `regWrite`, `memRead`, `memWrite`, `memToReg`, `pcSelJump`, `pcSelBranch` and `regJump` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| pcPlus4 | input | 32 | Address of the next sequential instruction |
| brCond | input | 1 | Branch condition result from the datapath ALU |
| regDstRd | output | 1 | Write register is rd (1) or rt (0) |
| aluSrcImm | output | 1 | Second ALU operand is the extended immediate |
| memToReg | output | 1 | Write-back value comes from the load path |
| regWrite | output | 1 | Register file write enable |
| memRead | output | 1 | Data memory read enable |
| memWrite | output | 1 | Data memory write enable |
| pcSelJump | output | 1 | Next PC is the absolute jump target |
| pcSelBranch | output | 1 | Next PC is the taken branch target |
| regJump | output | 1 | Next PC comes from a register (indirect jump) |
| illegalInstr | output | 1 | Instruction not recognised |
| aluOp | output | 4 | ALU operation or branch condition code |
| jumpTarget | output | 32 | Absolute jump destination |
| branchOffset | output | 32 | Word-aligned signed branch displacement |

## Verification
Every output depends combinationally on `instr`, `pcPlus4` and `brCond`. Each result is therefore due in the same cycle as its stimulus, after zero clock edges. The bench applies a new stimulus just after a rising edge and compares all outputs at the following falling edge, so values have half a period to settle and no sample meets a changing input. The branch target is checked by adding `branchOffset` to the applied PC+4 at that same sample point.

// File: rtl/ctrl_dec_pkg.sv
package ctrl_dec_pkg;

  localparam int INSTR_W  = 32;
  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int ALU_OP_W = 4;

  localparam logic [OP_W-1:0] OP_REG   = 6'd0;
  localparam logic [OP_W-1:0] OP_JMP   = 6'd2;
  localparam logic [OP_W-1:0] OP_JLINK = 6'd3;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE   = 6'd5;
  localparam logic [OP_W-1:0] OP_BLEZ  = 6'd6;
  localparam logic [OP_W-1:0] OP_BGTZ  = 6'd7;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'd8;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'd10;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'd12;
  localparam logic [OP_W-1:0] OP_ORI   = 6'd13;
  localparam logic [OP_W-1:0] OP_XORI  = 6'd14;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'd35;
  localparam logic [OP_W-1:0] OP_STORE = 6'd43;

  localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
  localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
  localparam logic [FN_W-1:0] FN_JREG = 6'd8;
  localparam logic [FN_W-1:0] FN_JRLK = 6'd9;
  localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
  localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
  localparam logic [FN_W-1:0] FN_AND  = 6'd36;
  localparam logic [FN_W-1:0] FN_OR   = 6'd37;
  localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
  localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
  localparam logic [FN_W-1:0] FN_SLT  = 6'd42;

  typedef enum logic [ALU_OP_W-1:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,
    ALU_NOR  = 4'd5,
    ALU_SLL  = 4'd6,
    ALU_SRL  = 4'd7,
    ALU_SLT  = 4'd8,
    ALU_CEQ  = 4'd9,
    ALU_CNE  = 4'd10,
    ALU_CLEZ = 4'd11,
    ALU_CGTZ = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic regDstRd;
    logic aluSrcImm;
    logic memToReg;
    logic regWrite;
    logic memRead;
    logic memWrite;
    logic pcSelJump;
    logic isBranch;
    logic regJump;
    logic illegal;
  } ctrl_strobes_t;

endpackage

// File: rtl/dec_main_ctrl.sv
module dec_main_ctrl
  import ctrl_dec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output ctrl_strobes_t   strobes
);

  logic fnArith;

  always_comb begin
    case (funct)
      FN_SLL, FN_SRL, FN_ADD, FN_SUB, FN_AND,
      FN_OR, FN_XOR, FN_NOR, FN_SLT: fnArith = 1'b1;
      default:                       fnArith = 1'b0;
    endcase
  end

  always_comb begin
    strobes           = '0;
    strobes.regDstRd  = (opcode == OP_REG);
    strobes.aluSrcImm = (opcode != OP_REG) && (opcode != OP_BEQ) && (opcode != OP_BNE);
    case (opcode)
      OP_REG: begin
        if (fnArith) begin
          strobes.regWrite = 1'b1;
        end else if (funct == FN_JREG) begin
          strobes.regJump = 1'b1;
        end else if (funct == FN_JRLK) begin
          strobes.regJump  = 1'b1;
          strobes.regWrite = 1'b1;
        end else begin
          strobes.illegal = 1'b1;
        end
      end
      OP_JMP:   strobes.pcSelJump = 1'b1;
      OP_JLINK: begin
        strobes.pcSelJump = 1'b1;
        strobes.regWrite  = 1'b1;
      end
      OP_BEQ, OP_BNE, OP_BLEZ, OP_BGTZ: strobes.isBranch = 1'b1;
      OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI: strobes.regWrite = 1'b1;
      OP_LOAD: begin
        strobes.regWrite = 1'b1;
        strobes.memRead  = 1'b1;
        strobes.memToReg = 1'b1;
      end
      OP_STORE: strobes.memWrite = 1'b1;
      default:  strobes.illegal  = 1'b1;
    endcase
  end

endmodule

// File: rtl/dec_alu_ctrl.sv
module dec_alu_ctrl
  import ctrl_dec_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output alu_op_e         aluSel
);

  alu_op_e fnSel;

  always_comb begin
    case (funct)
      FN_ADD:  fnSel = ALU_ADD;
      FN_SUB:  fnSel = ALU_SUB;
      FN_AND:  fnSel = ALU_AND;
      FN_OR:   fnSel = ALU_OR;
      FN_XOR:  fnSel = ALU_XOR;
      FN_NOR:  fnSel = ALU_NOR;
      FN_SLL:  fnSel = ALU_SLL;
      FN_SRL:  fnSel = ALU_SRL;
      FN_SLT:  fnSel = ALU_SLT;
      default: fnSel = ALU_ADD;
    endcase
  end

  always_comb begin
    case (opcode)
      OP_REG:            aluSel = fnSel;
      OP_SLTI:           aluSel = ALU_SLT;
      OP_ANDI:           aluSel = ALU_AND;
      OP_ORI:            aluSel = ALU_OR;
      OP_XORI:           aluSel = ALU_XOR;
      OP_BEQ:            aluSel = ALU_CEQ;
      OP_BNE:            aluSel = ALU_CNE;
      OP_BLEZ:           aluSel = ALU_CLEZ;
      OP_BGTZ:           aluSel = ALU_CGTZ;
      default:           aluSel = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/dec_imm_path.sv
module dec_imm_path #(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int JIMM_W  = 26,
  parameter int ALIGN   = 2
) (
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] pcPlus4,
  output logic [XLEN-1:0] jumpTarget,
  output logic [XLEN-1:0] branchOffset
);

  localparam int PC_HI_W = XLEN - JIMM_W - ALIGN;
  localparam int EXT_W   = XLEN - IMM_W - ALIGN;

  logic [IMM_W-1:0]  imm16;
  logic [JIMM_W-1:0] imm26;

  assign imm16 = instr[IMM_W-1:0];
  assign imm26 = instr[JIMM_W-1:0];

  generate
    if (PC_HI_W > 0) begin : g_region
      assign jumpTarget = {pcPlus4[XLEN-1 -: PC_HI_W], imm26, {ALIGN{1'b0}}};
    end else begin : g_flat
      assign jumpTarget = {imm26, {ALIGN{1'b0}}};
    end
  endgenerate

  assign branchOffset = {{EXT_W{imm16[IMM_W-1]}}, imm16, {ALIGN{1'b0}}};

endmodule

// File: rtl/ctrl_decoder.sv
module ctrl_decoder
  import ctrl_dec_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [31:0] pcPlus4,
  input  logic        brCond,
  output logic        regDstRd,
  output logic        aluSrcImm,
  output logic        memToReg,
  output logic        regWrite,
  output logic        memRead,
  output logic        memWrite,
  output logic        pcSelJump,
  output logic        pcSelBranch,
  output logic        regJump,
  output logic        illegalInstr,
  output logic [3:0]  aluOp,
  output logic [31:0] jumpTarget,
  output logic [31:0] branchOffset
);

  ctrl_strobes_t strobes;
  alu_op_e       aluSel;
  logic [OP_W-1:0] opcode;
  logic [FN_W-1:0] funct;

  assign opcode = instr[INSTR_W-1 -: OP_W];
  assign funct  = instr[FN_W-1:0];

  dec_main_ctrl i_main (
    .opcode  (opcode),
    .funct   (funct),
    .strobes (strobes)
  );

  dec_alu_ctrl i_alu (
    .opcode (opcode),
    .funct  (funct),
    .aluSel (aluSel)
  );

  dec_imm_path #(
    .XLEN   (INSTR_W),
    .IMM_W  (16),
    .JIMM_W (26),
    .ALIGN  (2)
  ) i_imm (
    .instr        (instr),
    .pcPlus4      (pcPlus4),
    .jumpTarget   (jumpTarget),
    .branchOffset (branchOffset)
  );

  assign regDstRd     = strobes.regDstRd;
  assign aluSrcImm    = strobes.aluSrcImm;
  assign memToReg     = strobes.memToReg;
  assign regWrite     = strobes.regWrite;
  assign memRead      = strobes.memRead;
  assign memWrite     = strobes.memWrite;
  assign pcSelJump    = strobes.pcSelJump;
  assign pcSelBranch  = strobes.isBranch & brCond;
  assign regJump      = strobes.regJump;
  assign illegalInstr = strobes.illegal;
  assign aluOp        = aluSel;

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
  input logic [31:0] instr,
  input logic [31:0] pcPlus4,
  input logic        brCond,
  input logic        regDstRd,
  input logic        aluSrcImm,
  input logic        memToReg,
  input logic        regWrite,
  input logic        memRead,
  input logic        memWrite,
  input logic        pcSelJump,
  input logic        pcSelBranch,
  input logic        regJump,
  input logic        illegalInstr,
  input logic [3:0]  aluOp,
  input logic [31:0] jumpTarget,
  input logic [31:0] branchOffset
);

  always_comb begin
    a_r3_mem_exclusive: assert (!(memRead && memWrite))
      else $error("R3: read and write enables both high");
    a_r3_steer_with_read: assert (memToReg == memRead)
      else $error("R3: load steer differs from read enable");
    a_r6_branch_needs_cond: assert (!pcSelBranch || brCond)
      else $error("R6: branch taken without condition");
    a_r5_one_pc_source: assert ($countones({pcSelJump, pcSelBranch, regJump}) <= 1)
      else $error("R5: more than one next-PC source");
    a_r13_illegal_quiet: assert (!illegalInstr ||
        !(regWrite || memRead || memWrite || pcSelJump || pcSelBranch || regJump))
      else $error("R13: side effect on an illegal word");
    a_r10_target_region: assert (jumpTarget[31:28] == pcPlus4[31:28] &&
        jumpTarget[1:0] == 2'b00)
      else $error("R10: jump target region or alignment wrong");
    a_r11_offset_sign: assert (branchOffset[31] == instr[15] &&
        branchOffset[1:0] == 2'b00)
      else $error("R11: branch offset sign or alignment wrong");
    a_r9_cond_only_branch: assert (pcSelBranch == 1'b0 ||
        (aluOp >= 4'd9 && aluOp <= 4'd12))
      else $error("R9: taken branch without condition code");
  end

endmodule

bind ctrl_decoder ctrl_decoder_chk i_chk (.*);

// File: tb/test_ctrl_decoder.sv
module test_ctrl_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] pcPlus4 = '0;
  logic        brCond = 1'b0;
  logic        regDstRd, aluSrcImm, memToReg, regWrite, memRead, memWrite;
  logic        pcSelJump, pcSelBranch, regJump, illegalInstr;
  logic [3:0]  aluOp;
  logic [31:0] jumpTarget, branchOffset;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ctrl_decoder i_ctrl_decoder (
    .instr(instr), .pcPlus4(pcPlus4), .brCond(brCond),
    .regDstRd(regDstRd), .aluSrcImm(aluSrcImm), .memToReg(memToReg),
    .regWrite(regWrite), .memRead(memRead), .memWrite(memWrite),
    .pcSelJump(pcSelJump), .pcSelBranch(pcSelBranch), .regJump(regJump),
    .illegalInstr(illegalInstr), .aluOp(aluOp),
    .jumpTarget(jumpTarget), .branchOffset(branchOffset)
  );

  typedef struct {
    bit rd, imm, m2r, wr, mrd, mwr, jmp, br, rj, ill;
    int alu;
  } exp_t;

  function automatic exp_t model(logic [31:0] w, bit cond);
    exp_t e;
    int op = int'(w[31:26]);
    int fn = int'(w[5:0]);
    e = '{default: 0};
    e.rd  = (op == 0);
    e.imm = (op != 0 && op != 4 && op != 5);
    if (op == 0) begin
      if      (fn == 32) begin e.wr = 1; e.alu = 0; end
      else if (fn == 34) begin e.wr = 1; e.alu = 1; end
      else if (fn == 36) begin e.wr = 1; e.alu = 2; end
      else if (fn == 37) begin e.wr = 1; e.alu = 3; end
      else if (fn == 38) begin e.wr = 1; e.alu = 4; end
      else if (fn == 39) begin e.wr = 1; e.alu = 5; end
      else if (fn == 0)  begin e.wr = 1; e.alu = 6; end
      else if (fn == 2)  begin e.wr = 1; e.alu = 7; end
      else if (fn == 42) begin e.wr = 1; e.alu = 8; end
      else if (fn == 8)  begin e.rj = 1; end
      else if (fn == 9)  begin e.rj = 1; e.wr = 1; end
      else e.ill = 1;
    end else if (op == 2) e.jmp = 1;
    else if (op == 3) begin e.jmp = 1; e.wr = 1; end
    else if (op >= 4 && op <= 7) begin e.br = cond; e.alu = op + 5; end
    else if (op == 8)  begin e.wr = 1; e.alu = 0; end
    else if (op == 10) begin e.wr = 1; e.alu = 8; end
    else if (op == 12) begin e.wr = 1; e.alu = 2; end
    else if (op == 13) begin e.wr = 1; e.alu = 3; end
    else if (op == 14) begin e.wr = 1; e.alu = 4; end
    else if (op == 35) begin e.wr = 1; e.mrd = 1; e.m2r = 1; end
    else if (op == 43) e.mwr = 1;
    else e.ill = 1;
    return e;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", req, what, instr, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] w, logic [31:0] pc, bit cond);
    exp_t e;
    logic [31:0] sx;
    @(posedge clk);
    #1;
    instr = w; pcPlus4 = pc; brCond = cond;
    @(negedge clk);
    e  = model(w, cond);
    sx = {{16{w[15]}}, w[15:0]};
    chk("R1",  "regDstRd",  {31'd0, regDstRd},  {31'd0, e.rd});
    chk("R2",  "aluSrcImm", {31'd0, aluSrcImm}, {31'd0, e.imm});
    chk("R3",  "memRead",   {31'd0, memRead},   {31'd0, e.mrd});
    chk("R3",  "memToReg",  {31'd0, memToReg},  {31'd0, e.m2r});
    chk("R3",  "memWrite",  {31'd0, memWrite},  {31'd0, e.mwr});
    chk("R4",  "regWrite",  {31'd0, regWrite},  {31'd0, e.wr});
    chk("R5",  "pcSelJump", {31'd0, pcSelJump}, {31'd0, e.jmp});
    chk("R6",  "pcSelBranch", {31'd0, pcSelBranch}, {31'd0, e.br});
    chk("R7_R8_R9", "aluOp", {28'd0, aluOp}, 32'(e.alu));
    chk("R10", "jumpTarget", jumpTarget, {pc[31:28], w[25:0], 2'b00});
    chk("R11", "branchTarget", pc + branchOffset, pc + (sx << 2));
    chk("R12", "regJump",   {31'd0, regJump},   {31'd0, e.rj});
    chk("R13", "illegal",   {31'd0, illegalInstr}, {31'd0, e.ill});
  endtask

  function automatic logic [31:0] mk(int op, int fn, logic [31:0] body);
    return {op[5:0], body[25:6], fn[5:0]};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 150000) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int ops[16] = '{0,2,3,4,5,6,7,8,10,12,13,14,35,43,1,63};
    int fns[13] = '{0,2,8,9,32,34,36,37,38,39,42,1,63};
    void'($urandom(32'hC0DE5EED));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all-zero word is a shift-left with no side effects beyond R4
    apply(32'h0, 32'h0, 1'b0);
    // R7 directed funct sweep
    foreach (fns[i]) apply(mk(0, fns[i], 32'h0123_4567), 32'h4000_0010, 1'b0);
    // R6 branches taken and not taken, negative and positive offsets
    for (int op = 4; op <= 7; op++) begin
      apply({op[5:0], 10'h3A5, 16'h8000}, 32'h8000_0004, 1'b1);
      apply({op[5:0], 10'h3A5, 16'h7FFF}, 32'h0000_1000, 1'b0);
    end
    // R6 brCond ignored on non-branch ops
    apply(mk(35, 0, 32'h0000_FFFC), 32'hFFFF_FFF0, 1'b1);
    apply(mk(2, 0, 32'h03FF_FFFF), 32'hF000_0000, 1'b1);
    // R10 jump field all ones and link jump
    apply({6'd3, 26'h3FF_FFFF}, 32'hA555_5554, 1'b0);
    // R13 illegal ops with cond set
    apply({6'd63, 26'h3FF_FFFF}, 32'h1234_5678, 1'b1);
    apply(mk(0, 1, 32'h0), 32'h0, 1'b1);
    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int op = ops[$urandom_range(15)];
      int fn = fns[$urandom_range(12)];
      logic [31:0] body = $urandom;
      if ($urandom_range(7) == 0) op = int'($urandom_range(63));
      apply(mk(op, fn, body), $urandom & 32'hFFFF_FFFC, 1'($urandom_range(1)));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule